// File: doc/BRIEF.md
# Triggered Waveform Capture Sequencer

This block decides, sample by sample, whether the current conversion result is written into a circular sample memory, and where. A conversion-rate strobe marks the cycles that carry a new sample. The block drives a write enable and a write address. The write address is a location counter that always names the next free slot. Recording is started by a trigger or by a gate. The trigger can come from an asynchronous pin or from a one-cycle software strobe. The gate is a second asynchronous pin. Recording stops when a programmed number of post-trigger samples has been taken, when the gate falls, when an abort arrives, or when the memory fills with wrap disabled.

One counter handles four uses: single post-trigger capture, several post-trigger captures stored back to back, continuous pre/post recording, and gated recording. The configuration word carries the following bits:

- arm
- pre/post
- auto-restart of the location counter
- wrap
- disarm at end of cycle
- gate mode

A 21-bit length input sets how many samples follow a trigger. The block reports its armed and active state, the pre/post bit, a sticky overflow flag, and a one-cycle interrupt pulse at the end of every cycle.

Top module: `capture_sequencer`

## Requirements
- R1: When the block is armed, not active and its pre/post bit is clear, a trigger makes it active. It then writes exactly `gate_len_i` samples (one per `sample_en_i` cycle) and falls inactive at the next sample slot after the last write. `irq_o` is high for the one cycle just after `active_o` falls. A length of 0 ends the cycle at the first sample slot without any write. While the block is not active, `wr_en_o` stays low.
- R2: If auto-restart is set, the trigger that starts a capture also sets the location to 0. If it is clear, the capture continues from the current location, so successive captures are stored one after another. After a write, `wr_addr_o` has advanced by one.
- R3: With wrap clear, a write at the last address (all ones) ends the cycle and clears `armed_o`, whatever the disarm-at-end bit. Later triggers then start nothing.
- R4: With wrap set, the address rolls from the last address to 0 and the block stays armed. `overflow_o` becomes 1 on any write at the last address. It stays 1 until a location clear is accepted.
- R5: A configuration write with pre/post=1 and arm=1 starts continuous recording only if the stored pre/post bit was already 1 before that write. This makes a first write (storing the bit) and a second write (starting) necessary. While recording continuously, every sample slot is written. A trigger then allows `gate_len_i` more samples before the cycle ends. `prepost_o` reads 0 once `active_o` has fallen.
- R6: In gate mode, the trigger pin and the software strobe are ignored. A rising gate edge starts a capture. Samples are written while the synchronized gate is high. The cycle ends, with `irq_o`, one cycle after the synchronized gate falls.
- R7: A disarm strobe, or a configuration write with arm=0 while active, clears `armed_o` at any time. If the block was active, this ends the cycle and pulses `irq_o`; otherwise no `irq_o` occurs. The abort cycle does not write.
- R8: With disarm-at-end set, a normal end of cycle clears `armed_o` and later triggers are ignored. With it clear, the block stays armed and accepts the next trigger.
- R9: `loc_clear_i` sets the location to 0 and clears `overflow_o` only while the block is not active. While active it has no effect.
- R10: A trigger pin rise set up before clock edge k makes `active_o` high after edge k+2. The software strobe acts at the edge where it is sampled. A trigger that arrives while post-trigger samples are being counted is ignored.
- R11: After reset, every output is 0 and the location is 0.
- R12: A configuration write with arm=1 while the block is active is ignored entirely. A configuration write while not active stores all mode bits and sets `armed_o` to the written arm value. Triggers in that same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en_i | input | 1 | A new conversion result is present this cycle |
| ext_trig_i | input | 1 | Asynchronous trigger pin, rising edge active |
| ext_gate_i | input | 1 | Asynchronous gate pin |
| sw_trig_i | input | 1 | One-cycle software trigger |
| disarm_i | input | 1 | One-cycle disarm / abort strobe |
| loc_clear_i | input | 1 | One-cycle location clear request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_arm_i | input | 1 | Written arm bit |
| cfg_prepost_i | input | 1 | Written pre/post bit |
| cfg_auto_reset_i | input | 1 | Written auto-restart bit |
| cfg_wrap_i | input | 1 | Written wrap bit |
| cfg_disarm_end_i | input | 1 | Written disarm-at-end bit |
| cfg_gate_mode_i | input | 1 | Written gate-mode bit |
| gate_len_i | input | DUR_W | Post-trigger sample count, taken at the trigger |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | ADDR_W | Location counter, the address written when wr_en_o is high |
| active_o | output | 1 | Recording cycle in progress |
| armed_o | output | 1 | Block armed |
| prepost_o | output | 1 | Stored pre/post bit |
| overflow_o | output | 1 | Sticky: location rolled past the last address |
| irq_o | output | 1 | One-cycle end-of-cycle interrupt request |

## Verification
`wr_en_o` and `wr_addr_o` respond in the same cycle to `sample_en_i`, the strobes and the stored state. Every other output follows one clock edge after the input that causes it. The exception is the pins: a pin edge acts two edges after the first edge that sees it, so `active_o` rises after edge k+2. The bench drives inputs at the falling edge and compares all outputs 1 ns later, before the next rising edge. A bench model advances at each rising edge, so a registered result is expected exactly one step after its cause, and a pin result three steps after the pin changes. The directed sequences add explicit checks of those counts: the write totals, the final addresses, the latency of the trigger pin, and the one-cycle gap before `irq_o`.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {
    REC_PRE  = 2'd0,
    REC_POST = 2'd1,
    REC_GATE = 2'd2
  } rec_mode_e;
endpackage

// File: rtl/cseq_edge_sync.sv
module cseq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/cseq_post_counter.sv
module cseq_post_counter #(
  parameter int DUR_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DUR_W-1:0] len_i,
  input  logic             dec_i,
  output logic [DUR_W-1:0] remain_o,
  output logic             last_o
);
  logic [DUR_W-1:0] remain_q;

  function automatic logic at_most_one(input logic [DUR_W-1:0] v);
    return v <= DUR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain_q <= '0;
    else if (load_i) remain_q <= len_i;
    else if (dec_i)  remain_q <= remain_q - 1'b1;
  end

  assign remain_o = remain_q;
  assign last_o   = at_most_one(remain_q);

  // R1: never counts a write past the programmed length
  p_no_underrun_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (remain_q != '0));
endmodule

// File: rtl/cseq_loc_counter.sv
module cseq_loc_counter #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_i,
  input  logic              step_i,
  input  logic              ovf_clr_i,
  output logic [ADDR_W-1:0] loc_o,
  output logic              last_o,
  output logic              ovf_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [ADDR_W-1:0] loc_q;
  logic              ovf_q;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      loc_q <= '0;
    else if (zero_i) loc_q <= '0;
    else if (step_i) loc_q <= bump(loc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovf_q <= 1'b0;
    else if (ovf_clr_i)         ovf_q <= 1'b0;
    else if (step_i && last_o)  ovf_q <= 1'b1;
  end

  assign loc_o  = loc_q;
  assign last_o = (loc_q == TOP_ADDR);
  assign ovf_o  = ovf_q;

  // R4: overflow flag is sticky until an accepted clear
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int ADDR_W      = 6,
  parameter int DUR_W       = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en_i,
  input  logic              ext_trig_i,
  input  logic              ext_gate_i,
  input  logic              sw_trig_i,
  input  logic              disarm_i,
  input  logic              loc_clear_i,
  input  logic              cfg_we_i,
  input  logic              cfg_arm_i,
  input  logic              cfg_prepost_i,
  input  logic              cfg_auto_reset_i,
  input  logic              cfg_wrap_i,
  input  logic              cfg_disarm_end_i,
  input  logic              cfg_gate_mode_i,
  input  logic [DUR_W-1:0]  gate_len_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              active_o,
  output logic              armed_o,
  output logic              prepost_o,
  output logic              overflow_o,
  output logic              irq_o
);
  import cseq_pkg::*;

  // stored state
  logic      armed_q, active_q, pp_q, irq_q;
  logic      ar_q, wrap_q, de_q, gm_q;
  rec_mode_e mode_q;

  // synchronized pin events
  logic trig_lvl, trig_prev, gate_lvl, gate_prev;
  logic trig_rise, gate_rise, gate_fall;

  // named internal events
  logic start_ev, kill, rec_ok, ovf_stop, norm_end, cycle_end, fell;
  logic start_trig, start_pre, pre_hit, load_len, dec_len;
  logic loc_zero, loc_ovf_clr, at_last, post_last, cfg_idle;
  logic [DUR_W-1:0] remain;

  cseq_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_trig_i),
    .level_o(trig_lvl), .prev_o(trig_prev));

  cseq_edge_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_gate_i),
    .level_o(gate_lvl), .prev_o(gate_prev));

  assign trig_rise = trig_lvl & ~trig_prev;
  assign gate_rise = gate_lvl & ~gate_prev;
  assign gate_fall = ~gate_lvl & gate_prev;

  // trigger source follows gate mode
  assign start_ev = gm_q ? gate_rise : (trig_rise | sw_trig_i);

  // abort of a running cycle
  assign kill = disarm_i | (cfg_we_i & ~cfg_arm_i & active_q);

  always_comb begin
    unique case (mode_q)
      REC_POST: rec_ok = (remain != '0);
      REC_GATE: rec_ok = gate_lvl;
      default:  rec_ok = 1'b1;
    endcase
  end

  assign wr_en_o   = active_q & sample_en_i & ~kill & rec_ok;
  assign ovf_stop  = wr_en_o & at_last & ~wrap_q;
  assign norm_end  = active_q & ~kill &
                     (((mode_q == REC_POST) & sample_en_i & post_last) |
                      ((mode_q == REC_GATE) & gate_fall));
  assign cycle_end = norm_end | ovf_stop;
  assign fell      = (kill & active_q) | cycle_end;

  assign cfg_idle   = cfg_we_i & ~active_q & ~disarm_i;
  assign start_trig = ~active_q & armed_q & ~pp_q & start_ev & ~cfg_we_i & ~disarm_i;
  assign start_pre  = cfg_idle & cfg_arm_i & cfg_prepost_i & pp_q;
  assign pre_hit    = active_q & ~kill & (mode_q == REC_PRE) & start_ev;
  assign load_len   = start_trig | pre_hit;
  assign dec_len    = wr_en_o & (mode_q == REC_POST);
  assign loc_zero   = (start_trig & ar_q) | (loc_clear_i & ~active_q);
  assign loc_ovf_clr = loc_clear_i & ~active_q;

  cseq_post_counter #(.DUR_W(DUR_W)) u_post (
    .clk(clk), .rst_n(rst_n), .load_i(load_len), .len_i(gate_len_i),
    .dec_i(dec_len), .remain_o(remain), .last_o(post_last));

  cseq_loc_counter #(.ADDR_W(ADDR_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .zero_i(loc_zero), .step_i(wr_en_o),
    .ovf_clr_i(loc_ovf_clr), .loc_o(wr_addr_o), .last_o(at_last),
    .ovf_o(overflow_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ar_q    <= 1'b0;
      wrap_q  <= 1'b0;
      de_q    <= 1'b0;
      gm_q    <= 1'b0;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
    end else if (cfg_we_i && !active_q) begin
      armed_q <= cfg_arm_i;
      ar_q    <= cfg_auto_reset_i;
      wrap_q  <= cfg_wrap_i;
      de_q    <= cfg_disarm_end_i;
      gm_q    <= cfg_gate_mode_i;
    end else if (kill || ovf_stop || (norm_end && de_q)) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pp_q     <= 1'b0;
      irq_q    <= 1'b0;
      mode_q   <= REC_POST;
    end else begin
      irq_q <= fell;
      if (fell)                        active_q <= 1'b0;
      else if (start_trig || start_pre) active_q <= 1'b1;
      if (cfg_idle)  pp_q <= cfg_prepost_i;
      else if (fell) pp_q <= 1'b0;
      if (start_pre)    mode_q <= REC_PRE;
      else if (load_len) mode_q <= gm_q ? REC_GATE : REC_POST;
    end
  end

  assign active_o  = active_q;
  assign armed_o   = armed_q;
  assign prepost_o = pp_q;
  assign irq_o     = irq_q;

  // R1: end of every cycle raises the request, and no write while idle
  p_irq_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> irq_q);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !wr_en_o);
  // R7: request only in the cycle after activity ended
  p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !active_q);
  // R2: a write advances the location
  p_loc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (wr_addr_o == $past(wr_addr_o) + 1'b1));
  // R3: write at the top without wrap halts and disarms
  p_wrapoff_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && at_last && !wrap_q) |=> (!active_q && !armed_q));
  // R4: write at the top rolls to zero and flags overflow
  p_roll_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && at_last) |=> (wr_addr_o == '0 && overflow_o));
  // R5: pre/post bit drops with active
  p_pp_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> !pp_q);
  // R9: clear request has no effect during a cycle
  p_clear_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_clear_i && active_q && !wr_en_o) |=> $stable(wr_addr_o));
endmodule

// File: tb/sim_capture_sequencer.sv
module sim_capture_sequencer;
  localparam int AW    = 6;
  localparam int DW    = 21;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 0, ext_trig = 0, ext_gate = 0, sw_trig = 0, disarm = 0;
  logic loc_clear = 0, cfg_we = 0, cfg_arm = 0, cfg_prepost = 0;
  logic cfg_ar = 0, cfg_wrap = 0, cfg_de = 0, cfg_gm = 0;
  logic [DW-1:0] gate_len = '0;
  logic wr_en_o, active_o, armed_o, prepost_o, overflow_o, irq_o;
  logic [AW-1:0] wr_addr_o;

  always #2.5 clk = ~clk;

  capture_sequencer #(.ADDR_W(AW), .DUR_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_en_i(sample_en), .ext_trig_i(ext_trig),
    .ext_gate_i(ext_gate), .sw_trig_i(sw_trig), .disarm_i(disarm),
    .loc_clear_i(loc_clear), .cfg_we_i(cfg_we), .cfg_arm_i(cfg_arm),
    .cfg_prepost_i(cfg_prepost), .cfg_auto_reset_i(cfg_ar), .cfg_wrap_i(cfg_wrap),
    .cfg_disarm_end_i(cfg_de), .cfg_gate_mode_i(cfg_gm), .gate_len_i(gate_len),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .active_o(active_o),
    .armed_o(armed_o), .prepost_o(prepost_o), .overflow_o(overflow_o),
    .irq_o(irq_o));

  int compared = 0, mismatched = 0, se_pct = 100, wcount = 0;
  bit irq_seen = 0, done = 0;
  string tag = "R11";

  // bench model state
  bit m_armed, m_active, m_pp, m_ar, m_wrap, m_de, m_gm, m_ovf, m_irq;
  int m_mode;  // 0 continuous, 1 counted, 2 gated
  int unsigned m_loc, m_rem;
  bit t1, t2, t3, g1, g2, g3;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_wr();
    bit ok;
    if (m_mode == 1)      ok = (m_rem != 0);
    else if (m_mode == 2) ok = g2;
    else                  ok = 1'b1;
    return m_active && sample_en && !disarm && !(cfg_we && !cfg_arm) && ok;
  endfunction

  task automatic model_step();
    bit we, fin, ovstop, ev, was_act;
    we = exp_wr(); was_act = m_active; fin = 0; ovstop = 0;
    ev = m_gm ? (g2 && !g3) : ((t2 && !t3) || sw_trig);
    m_irq = 0;
    if (disarm) begin
      m_armed = 0;
      if (was_act) fin = 1;
    end else if (cfg_we && !was_act) begin
      m_ar = cfg_ar; m_wrap = cfg_wrap; m_de = cfg_de; m_gm = cfg_gm;
      m_armed = cfg_arm;
      if (cfg_arm && cfg_prepost && m_pp) begin m_active = 1; m_mode = 0; end
      m_pp = cfg_prepost;
    end else if (cfg_we && !cfg_arm) begin
      m_armed = 0; fin = 1;
    end else if (was_act) begin
      if (we) begin
        if (m_loc == DEPTH - 1) begin m_ovf = 1; if (!m_wrap) ovstop = 1; end
        m_loc = (m_loc + 1) % DEPTH;
      end
      case (m_mode)
        1: begin if (sample_en && m_rem <= 1) fin = 1; if (we) m_rem--; end
        2: if (!g2 && g3) fin = 1;
        default: if (ev) begin m_mode = m_gm ? 2 : 1; m_rem = gate_len; end
      endcase
      if (ovstop) begin fin = 1; m_armed = 0; end
      else if (fin && m_de) m_armed = 0;
    end else if (m_armed && !m_pp && ev) begin
      m_active = 1; m_mode = m_gm ? 2 : 1; m_rem = gate_len;
      if (m_ar) m_loc = 0;
    end
    if (fin) begin m_active = 0; m_irq = 1; m_pp = 0; end
    if (loc_clear && !was_act) begin m_loc = 0; m_ovf = 0; end
    t3 = t2; t2 = t1; t1 = ext_trig;
    g3 = g2; g2 = g1; g1 = ext_gate;
  endtask

  task automatic compare_all();
    chk(wr_en_o == exp_wr(), tag, "wr_en", wr_en_o, exp_wr());
    chk(wr_addr_o == m_loc[AW-1:0], tag, "wr_addr", wr_addr_o, m_loc);
    chk(active_o == m_active, tag, "active", active_o, m_active);
    chk(armed_o == m_armed, tag, "armed", armed_o, m_armed);
    chk(prepost_o == m_pp, tag, "prepost", prepost_o, m_pp);
    chk(overflow_o == m_ovf, tag, "overflow", overflow_o, m_ovf);
    chk(irq_o == m_irq, tag, "irq", irq_o, m_irq);
  endtask

  task automatic step();
    sample_en = ($urandom_range(99) < se_pct);
    #1;
    compare_all();
    if (wr_en_o) wcount++;
    if (irq_o) irq_seen = 1;
    @(posedge clk);
    model_step();
    @(negedge clk);
    sw_trig = 0; disarm = 0; loc_clear = 0; cfg_we = 0;
  endtask

  task automatic wcfg(input bit arm, pp, ar, wr, de, gm);
    cfg_we = 1; cfg_arm = arm; cfg_prepost = pp;
    cfg_ar = ar; cfg_wrap = wr; cfg_de = de; cfg_gm = gm;
    step();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk({wr_en_o, active_o, armed_o, prepost_o, overflow_o, irq_o} == 6'b0,
        "R11", "reset outputs", {active_o, armed_o, irq_o}, 0);
    chk(wr_addr_o == 0, "R11", "reset addr", wr_addr_o, 0);
    @(negedge clk);

    // R1 single post-trigger capture of 5 samples
    tag = "R1"; gate_len = 5;
    wcfg(1, 0, 1, 1, 0, 0);
    wcount = 0; sw_trig = 1; step();
    repeat (12) step();
    chk(wcount == 5, "R1", "write count", wcount, 5);
    chk(wr_addr_o == 5, "R1", "final addr", wr_addr_o, 5);

    // R10 pin latency and retrigger ignored
    tag = "R10"; gate_len = 20; ext_trig = 1;
    step(); chk(active_o == 0, "R10", "active after k", active_o, 0);
    step(); chk(active_o == 0, "R10", "active after k+1", active_o, 0);
    step(); chk(active_o == 1, "R10", "active after k+2", active_o, 1);
    sw_trig = 1; step(); ext_trig = 0;
    repeat (30) step();
    chk(wr_addr_o == 20, "R10", "no restart addr", wr_addr_o, 20);

    // R2 back-to-back captures, then auto-restart
    tag = "R2"; gate_len = 4;
    wcfg(1, 0, 0, 1, 0, 0);
    sw_trig = 1; step(); repeat (8) step();
    sw_trig = 1; step(); repeat (8) step();
    chk(wr_addr_o == 28, "R2", "sequential addr", wr_addr_o, 28);
    wcfg(1, 0, 1, 1, 0, 0);
    sw_trig = 1; step(); repeat (8) step();
    chk(wr_addr_o == 4, "R2", "auto-restart addr", wr_addr_o, 4);

    // R8 disarm at end
    tag = "R8"; gate_len = 3;
    wcfg(1, 0, 1, 1, 1, 0);
    sw_trig = 1; step(); repeat (6) step();
    chk(armed_o == 0, "R8", "disarmed at end", armed_o, 0);
    sw_trig = 1; step(); repeat (4) step();
    chk(active_o == 0, "R8", "trigger ignored", active_o, 0);
    chk(wr_addr_o == 3, "R8", "addr unchanged", wr_addr_o, 3);

    // R3 wrap off stops at the top
    tag = "R3";
    loc_clear = 1; step();
    wcfg(1, 0, 0, 0, 0, 0); gate_len = 100;
    sw_trig = 1; step(); repeat (70) step();
    chk(armed_o == 0 && active_o == 0, "R3", "halted", {armed_o, active_o}, 0);
    chk(wr_addr_o == 0, "R3", "addr after top", wr_addr_o, 0);
    sw_trig = 1; step(); repeat (5) step();
    chk(active_o == 0, "R3", "later trigger ignored", active_o, 0);

    // R4 wrap on rolls over, sticky overflow
    tag = "R4";
    chk(overflow_o == 1, "R4", "overflow set", overflow_o, 1);
    loc_clear = 1; step();
    chk(overflow_o == 0, "R4", "overflow cleared", overflow_o, 0);
    wcfg(1, 0, 0, 1, 0, 0); gate_len = 40;
    sw_trig = 1; step(); repeat (45) step();
    sw_trig = 1; step(); repeat (45) step();
    chk(wr_addr_o == 16, "R4", "rolled addr", wr_addr_o, 16);
    chk(overflow_o == 1 && armed_o == 1, "R4", "ovf and armed", {overflow_o, armed_o}, 3);

    // R9 clear ignored while active
    tag = "R9"; gate_len = 30;
    sw_trig = 1; step(); step();
    loc_clear = 1; step();
    repeat (35) step();
    chk(wr_addr_o == 46, "R9", "clear ignored", wr_addr_o, 46);
    loc_clear = 1; step();
    chk(wr_addr_o == 0 && overflow_o == 0, "R9", "clear idle", wr_addr_o, 0);

    // R12 config write during activity ignored
    tag = "R12";
    sw_trig = 1; step(); step();
    wcfg(1, 0, 1, 0, 1, 0);
    repeat (35) step();
    chk(armed_o == 1, "R12", "still armed", armed_o, 1);
    chk(wr_addr_o == 30, "R12", "addr", wr_addr_o, 30);

    // R5 pre/post two-write start
    tag = "R5";
    loc_clear = 1; step();
    wcfg(0, 1, 0, 1, 0, 0);
    chk(active_o == 0 && prepost_o == 1, "R5", "first write", {active_o, prepost_o}, 1);
    wcfg(1, 1, 0, 1, 0, 0);
    chk(active_o == 1, "R5", "second write starts", active_o, 1);
    repeat (100) step();
    chk(overflow_o == 1, "R5", "circular overflow", overflow_o, 1);
    gate_len = 7; irq_seen = 0;
    sw_trig = 1; step(); repeat (10) step();
    chk(active_o == 0 && prepost_o == 0, "R5", "end and bit cleared", {active_o, prepost_o}, 0);
    chk(irq_seen, "R5", "irq", irq_seen, 1);
    chk(wr_addr_o == 44, "R5", "addr", wr_addr_o, 44);

    // R6 gate mode
    tag = "R6";
    wcfg(1, 0, 1, 1, 0, 1);
    ext_gate = 1; sw_trig = 1; step();
    repeat (11) step();
    ext_gate = 0; irq_seen = 0;
    repeat (6) step();
    chk(irq_seen, "R6", "irq on gate low", irq_seen, 1);
    chk(active_o == 0, "R6", "stopped", active_o, 0);
    chk(wr_addr_o == 11, "R6", "gated writes", wr_addr_o, 11);

    // R7 aborts
    tag = "R7";
    wcfg(1, 0, 1, 1, 0, 0); gate_len = 50;
    sw_trig = 1; step(); repeat (5) step();
    irq_seen = 0; disarm = 1; step(); step();
    chk(active_o == 0 && armed_o == 0, "R7", "disarm abort", {active_o, armed_o}, 0);
    chk(irq_seen, "R7", "disarm irq", irq_seen, 1);
    wcfg(1, 0, 1, 1, 0, 0);
    sw_trig = 1; step(); repeat (3) step();
    irq_seen = 0; wcfg(0, 0, 1, 1, 0, 0); step();
    chk(active_o == 0 && irq_seen, "R7", "write abort", {active_o, irq_seen}, 1);
    irq_seen = 0; disarm = 1; step(); step();
    chk(irq_seen == 0, "R7", "idle disarm no irq", irq_seen, 0);

    // constrained random mix
    tag = "R1"; se_pct = 70;
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) tag = (i % 1000 == 0) ? "R1" : "R12";
      if ($urandom_range(99) < 3) sw_trig = 1;
      if ($urandom_range(199) < 1) disarm = 1;
      if ($urandom_range(99) < 2) loc_clear = 1;
      if ($urandom_range(99) < 5) ext_trig = ~ext_trig;
      if ($urandom_range(99) < 4) ext_gate = ~ext_gate;
      if ($urandom_range(99) < 5) gate_len = DW'($urandom_range(30));
      if ($urandom_range(99) < 3) begin
        cfg_we = 1; cfg_arm = ($urandom_range(9) < 8);
        cfg_prepost = ($urandom_range(3) == 0); cfg_ar = $urandom_range(1);
        cfg_wrap = ($urandom_range(3) != 0); cfg_de = ($urandom_range(3) == 0);
        cfg_gm = ($urandom_range(4) == 0);
      end
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule